// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus that a MAC uses to configure and monitor Ethernet PHYs. A host loads a 16-bit write-data register, selects the frame mode (clause 22 or clause 45) and whether a preamble is sent, then issues a command. The command carries a 2-bit operation code, a 5-bit PHY address and a 5-bit register or device address. The block builds the management frame from these fields and shifts it out on MDIO. MDC is produced by a programmable divider.

For reads, the block releases MDIO at the turnaround and shifts in 16 data bits. It then reports the result through a read-data word and a valid flag. Write-side and read-side pending flags show which kind of frame is in progress, and a busy output covers the whole frame.

A clause 45 access takes two commands. The first is an address command that carries the target register address in the write-data register and the device number in the address field. A read, read-with-increment or write command to the same PHY and device follows it.

Top module: `mdio_master`

## Requirements
- R1: In clause 22 mode (`cfg_c45`=0) the frame starts with 01. Operation code 0 is a write sent with wire opcode 01, and code 1 is a read sent with wire opcode 10. Codes 2 and 3 are ignored: no frame starts, and no flag changes.
- R2: In clause 45 mode (`cfg_c45`=1) the frame starts with 00 and the wire opcode equals the operation code. Code 0 is an address frame and code 1 is a write; both carry the write-data register in the 16-bit data field. Code 2 (read with post-increment) and code 3 (plain read) are reads.
- R3: Frame order, every field sent MSB first: 32 ones when `cfg_pre`=1 (none when 0), then the start field, opcode, 5-bit PHY address, 5-bit register/device address, 2 turnaround bits and 16 data bits. A frame therefore has 64 or 32 MDC rising edges.
- R4: Write and address frames drive every bit, with turnaround 10. Read frames hold `mdio_oe` low from the first turnaround bit to the end of the frame. MDIO is undriven whenever the block is idle.
- R5: `wr_pending` rises on the clock edge that accepts a write or address command and falls when the last bit has been shifted out.
- R6: `rd_pending` rises on the edge that accepts a read, and `rd_valid` is cleared on that same edge. When the read finishes, `rd_pending` falls and `rd_valid` is set only if the PHY drove the second turnaround bit low.
- R7: Each MDC high phase and each MDC low phase lasts `cfg_div`+1 clock cycles. MDC is low whenever no frame is in progress.
- R8: MDIO outputs change only while MDC is low. Input data is sampled on the MDC rising edge, and the 16 read bits are assembled MSB first into `rd_data`.
- R9: `busy` is high from command acceptance to frame end. A command presented while busy is ignored and does not alter the frame in flight.
- R10: `rd_data` changes only at the end of a read frame. Write and address frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_c45 | input | 1 | Frame mode: 0 clause 22, 1 clause 45 |
| cfg_pre | input | 1 | Send 32-bit preamble when 1 |
| cfg_div | input | DIV_W | MDC half-period in clocks minus one |
| wdata_load | input | 1 | Load `wdata_in` into the write-data register |
| wdata_in | input | 16 | Write data or clause 45 register address |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address (clause 22) or device number (clause 45) |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Frame in progress |
| wr_pending | output | 1 | Write or address frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read completed with a valid turnaround |
| rd_data | output | 16 | Data from the last read |

## Verification
A wrong bit index or a wrong shift register content shows up on the wire at the very next MDC rising edge. It appears as a misplaced field or an output-enable that drops at the wrong bit, and the bench catches it by comparing every captured bit against a frame it builds from the field encodings. Divider faults change the spacing between MDC edges within the first bit. Errors in the frame-end logic are visible at the end of the frame: the pending flags clear late or stay set, busy never falls, or `rd_data`/`rd_valid` hold stale values. A fault in command gating shows as a second frame or a mutated frame when a command is issued mid-transfer or with an unsupported clause 22 code.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_c45,
  input  logic             cfg_pre,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             wdata_load,
  input  logic [15:0]      wdata_in,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             wr_pending,
  output logic             rd_pending,
  output logic             rd_valid,
  output logic [15:0]      rd_data
);
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_BITS + 14);
  localparam logic [IDX_W-1:0] TA2_POS  = IDX_W'(PRE_BITS + 15);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(PRE_BITS + 16);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

  logic [15:0]           wdata_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic [DIV_W-1:0]      cnt;
  logic [15:0]           rx;
  logic                  active, is_rd, ta_ok;

  wire cmd_ok  = cfg_c45 || !cmd_op[1];
  wire accept  = cmd_valid && !active && cmd_ok;
  wire cmd_rd  = cfg_c45 ? cmd_op[1] : cmd_op[0];
  wire [1:0] wire_op = cfg_c45 ? cmd_op : (cmd_op[0] ? 2'b10 : 2'b01);
  wire [1:0] start   = cfg_c45 ? 2'b00 : 2'b01;
  wire [FRAME_BITS-1:0] frame = {{PRE_BITS{1'b1}}, start, wire_op, cmd_phy, cmd_reg,
                                 cmd_rd ? 2'b11 : 2'b10, cmd_rd ? 16'hFFFF : wdata_q};
  wire tick = (cnt == cfg_div);

  assign busy    = active;
  assign mdio_o  = shreg[FRAME_BITS-1];
  assign mdio_oe = active && !(is_rd && idx >= TA_POS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wdata_q <= '0;
    else if (wdata_load) wdata_q <= wdata_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; idx <= '0; cnt <= '0; rx <= '0;
      active <= 1'b0; is_rd <= 1'b0; ta_ok <= 1'b0; mdc <= 1'b0;
      wr_pending <= 1'b0; rd_pending <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else if (accept) begin
      active <= 1'b1;
      is_rd  <= cmd_rd;
      shreg  <= cfg_pre ? frame : (frame << PRE_BITS);
      idx    <= cfg_pre ? '0 : IDX_W'(PRE_BITS);
      cnt    <= '0;
      mdc    <= 1'b0;
      ta_ok  <= 1'b0;
      if (cmd_rd) begin
        rd_pending <= 1'b1;
        rd_valid   <= 1'b0;
      end else begin
        wr_pending <= 1'b1;
      end
    end else if (active) begin
      if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (is_rd && idx == TA2_POS) ta_ok <= !mdio_i;
          if (is_rd && idx >= DATA_POS) rx <= {rx[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (idx == LAST_POS) begin
            active     <= 1'b0;
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            shreg      <= '0;
            if (is_rd) begin
              rd_valid <= ta_ok;
              rd_data  <= rx;
            end
          end else begin
            shreg <= shreg << 1;
            idx   <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        wr_pending,
  input logic        rd_pending,
  input logic        rd_valid,
  input logic [15:0] rd_data
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R7
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R4
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wr_pending ^ rd_pending)); // R5
  AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pending || rd_pending) |-> busy); // R9
  AST_VALID_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending |-> !rd_valid); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pending && !$past(rd_pending)) |-> $stable(rd_data)); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .wr_pending(wr_pending), .rd_pending(rd_pending),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_c45 = 1'b0, cfg_pre = 1'b1;
  logic [7:0] cfg_div = 8'd0;
  logic wdata_load = 1'b0;
  logic [15:0] wdata_in = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, wr_pending, rd_pending, rd_valid;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mdio_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_c45(cfg_c45), .cfg_pre(cfg_pre), .cfg_div(cfg_div),
    .wdata_load(wdata_load), .wdata_in(wdata_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .wr_pending(wr_pending), .rd_pending(rd_pending),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic       c45;
    logic       pre;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] rg;
    logic [15:0] wd;
    logic [15:0] resp;
    logic       ta;
    logic [3:0] div;
  } vec_t;

  localparam vec_t TAB [8] = '{
    '{1'b0, 1'b1, 2'd0, 5'h01, 5'h00, 16'h1234, 16'h0000, 1'b0, 4'd1},
    '{1'b0, 1'b1, 2'd1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3, 1'b0, 4'd0},
    '{1'b1, 1'b1, 2'd0, 5'h03, 5'h01, 16'h8001, 16'h0000, 1'b0, 4'd1},
    '{1'b1, 1'b1, 2'd1, 5'h03, 5'h1F, 16'hFFFF, 16'h0000, 1'b0, 4'd2},
    '{1'b1, 1'b1, 2'd2, 5'h10, 5'h05, 16'h0000, 16'h0001, 1'b0, 4'd0},
    '{1'b1, 1'b1, 2'd3, 5'h0A, 5'h1E, 16'h0000, 16'h8000, 1'b0, 4'd3},
    '{1'b0, 1'b0, 2'd0, 5'h12, 5'h0A, 16'h0F0F, 16'h0000, 1'b0, 4'd0},
    '{1'b0, 1'b0, 2'd1, 5'h07, 5'h03, 16'h0000, 16'h5A5A, 1'b0, 4'd1}
  };

  int checks = 0, fails = 0, cycles = 0;
  int n_rise = 0, base = 0;
  logic [63:0] cap_d = '0, cap_oe = '0;
  logic [15:0] resp_data = '0;
  logic resp_ta = 1'b0;
  time t_last = 0, t_per = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      check(1'b0, "watchdog", 64'(cycles), 64'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(posedge mdc) begin
    cap_d  = {cap_d[62:0], mdio_oe ? mdio_o : 1'b0};
    cap_oe = {cap_oe[62:0], mdio_oe};
    n_rise++;
    t_per  = $time - t_last;
    t_last = $time;
  end

  always @(negedge mdc) begin
    int p;
    p = base + n_rise;
    if (p == 47) mdio_i = resp_ta;
    else if (p >= 48 && p < 64) mdio_i = resp_data[63 - p];
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(vec_t v);
    logic rd;
    logic [1:0] opw;
    rd  = v.c45 ? v.op[1] : (v.op == 2'd1);
    opw = v.c45 ? v.op : (v.op == 2'd0 ? 2'b01 : 2'b10);
    return {32'hFFFF_FFFF, v.c45 ? 2'b00 : 2'b01, opw, v.phy, v.rg,
            rd ? 2'b00 : 2'b10, rd ? 16'h0000 : v.wd};
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic issue(input vec_t v);
    cfg_c45 = v.c45; cfg_pre = v.pre; cfg_div = 8'(v.div);
    wdata_in = v.wd; wdata_load = 1'b1;
    @(negedge clk);
    wdata_load = 1'b0;
    resp_data = v.resp; resp_ta = v.ta;
    base = v.pre ? 0 : 32; n_rise = 0; cap_d = '0; cap_oe = '0;
    cmd_op = v.op; cmd_phy = v.phy; cmd_reg = v.rg; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_frame(input vec_t v, input bit mid_cmd);
    logic rd;
    logic [63:0] mask, ef, eo;
    logic [15:0] prev;
    rd   = v.c45 ? v.op[1] : (v.op == 2'd1);
    mask = v.pre ? '1 : 64'h0000_0000_FFFF_FFFF;
    ef   = exp_frame(v) & mask;
    eo   = (rd ? ~64'h3FFFF : '1) & mask;
    prev = rd_data;
    issue(v);
    check(busy, "R9 busy after accept", 64'(busy), 64'd1);
    check(wr_pending == !rd && rd_pending == rd, rd ? "R6 rd_pending set" : "R5 wr_pending set",
          {62'd0, wr_pending, rd_pending}, {62'd0, !rd, rd});
    if (rd) check(rd_valid == 1'b0, "R6 valid cleared at accept", 64'(rd_valid), 64'd0);
    if (mid_cmd) begin
      repeat (20) @(negedge clk);
      cmd_op = 2'd1; cmd_phy = ~v.phy; cmd_reg = ~v.rg; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_idle();
    check(!busy && !wr_pending && !rd_pending, "R5 R6 flags clear at end",
          {61'd0, busy, wr_pending, rd_pending}, 64'd0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 R4 idle bus", {62'd0, mdc, mdio_oe}, 64'd0);
    check(n_rise == (v.pre ? 64 : 32), "R3 edge count", 64'(n_rise), v.pre ? 64'd64 : 64'd32);
    check((cap_d & mask) == ef, v.c45 ? "R2 R3 frame bits" : "R1 R3 frame bits", cap_d & mask, ef);
    check((cap_oe & mask) == eo, "R4 output enable pattern", cap_oe & mask, eo);
    check(t_per == 64'(2 * (v.div + 1) * 4), "R7 MDC period", 64'(t_per), 64'(2 * (v.div + 1) * 4));
    if (rd) begin
      check(rd_data == v.resp, "R8 read data", 64'(rd_data), 64'(v.resp));
      check(rd_valid == !v.ta, "R6 read valid", 64'(rd_valid), 64'(!v.ta));
    end else begin
      check(rd_data == prev, "R10 rd_data unchanged by write", 64'(rd_data), 64'(prev));
    end
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check(!busy && !mdc && !mdio_oe && !wr_pending && !rd_pending && !rd_valid && rd_data == 0,
          "R7 reset state", {58'd0, busy, mdc, mdio_oe, wr_pending, rd_pending, rd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) run_frame(TAB[i], 1'b0);

    v = TAB[1]; v.ta = 1'b1; v.resp = 16'h3C3C;
    run_frame(v, 1'b0);

    v = TAB[5]; v.resp = 16'h7E81;
    run_frame(v, 1'b0);
    v = TAB[0]; v.wd = 16'hBEEF;
    run_frame(v, 1'b1);
    repeat (20) @(negedge clk);
    check(!busy && !rd_pending, "R9 command while busy ignored", {62'd0, busy, rd_pending}, 64'd0);
    check(rd_data == 16'h7E81, "R10 rd_data held", 64'(rd_data), 64'h7E81);

    cfg_c45 = 1'b0; cmd_op = 2'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy && !wr_pending && !rd_pending && mdc == 1'b0, "R1 clause 22 code 2 ignored",
          {61'd0, busy, wr_pending, rd_pending}, 64'd0);
    cmd_op = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy && !wr_pending && !rd_pending && rd_data == 16'h7E81, "R1 clause 22 code 3 ignored",
          {45'd0, busy, wr_pending, rd_pending, rd_data}, {48'd0, 16'h7E81});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule